// File: doc/BRIEF.md
# Bank Page Buffer with Periodic Video Port

This block is a row-wide staging buffer that sits on one memory bank's sense amplifiers. It holds exactly one bank row and is direct mapped to that bank. Host traffic reaches it through a block-wide global bus port. A full-row read port fills it from the memory array. A narrower video port is handed one row segment on a fixed period.

Blocks inside a row are addressed as rectangular screen tiles. A request carries a tile column and a tile row, not a linear offset. Every block write goes into the buffer and also goes straight out to the array, so the array never lags behind the buffer. When the host touches a row the buffer does not hold, the buffer first fetches that whole row from the array, and the host port reports not-ready while the fetch runs.

A free-running slot timer decides when the video port is served. In a video slot cycle the host port is held off, so the video transfer always wins.

Top module: `pagebuf_bank`

## Requirements
- R1: After reset the buffer holds no valid row and its contents read as zero. `host_ack`, `vid_valid` and `mem_wr_en` are low, and `host_rdy` is high.
- R2: Block (`host_bx`, `host_by`) has index `host_by*TILE_COLS + host_bx`. It occupies bits `[index*BLK_W +: BLK_W]` of the row, and that index is the value driven on `mem_wr_blk`.
- R3: A request to a row other than the held one, or any request while no row is valid, starts a full-row fetch from `mem_rd_row`. `host_rdy` is low during the fetch. The row is captured after `LOAD_CYC` cycles, and the request is then served, so `host_ack` comes `LOAD_CYC+2` cycles after the request is first seen.
- R4: A read that hits the held row is accepted in the cycle it is presented while `host_rdy` is high. `host_ack` and `host_rdata` follow one cycle later.
- R5: A write that hits updates the addressed block. In the same cycle as `host_ack`, the block is written through with one `mem_wr_en` pulse carrying the row, the block index and the data.
- R6: A video slot occurs every `VID_PERIOD` cycles. The first `vid_valid` pulse comes `VID_PERIOD` cycles after reset is released, and each pulse lasts one cycle.
- R7: `vid_data` is segment `vid_seg` of the buffer, bits `[vid_seg*VID_W +: VID_W]`. The segment number starts at 0 and advances by one per slot, wrapping from `NSEG-1` to 0.
- R8: In the cycle that a video slot is due, `host_rdy` is low. A hit request held through that cycle is accepted one cycle later.
- R9: Data read after a row has been evicted and fetched again equals the last data written to it, which shows the array was kept current.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host request, held until `host_ack` |
| host_we | input | 1 | 1 = block write, 0 = block read |
| host_row | input | ROW_AW | Bank row of the request |
| host_bx | input | BXW | Tile column of the block |
| host_by | input | BYW | Tile row of the block |
| host_wdata | input | BLK_W | Write data |
| host_rdy | output | 1 | Host port may accept this cycle |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | BLK_W | Read data, valid with `host_ack` |
| mem_rd_row | output | ROW_AW | Row being fetched from the array |
| mem_rd_data | input | ROW_W | Full row returned by the array |
| mem_wr_en | output | 1 | Write-through strobe |
| mem_wr_row | output | ROW_AW | Write-through row |
| mem_wr_blk | output | BIW | Write-through block index |
| mem_wr_data | output | BLK_W | Write-through data |
| vid_valid | output | 1 | Video segment strobe |
| vid_seg | output | SEGW | Segment number delivered |
| vid_data | output | VID_W | Segment contents |

## Verification
A wrong row tag or valid bit shows up at the ports on the very next request. It appears either as a hit latency of one cycle where `LOAD_CYC+2` was due, or the reverse, and a wrong fetch returns stale data on `host_rdata`. A lost write-through does not show at once. It appears only when the row is evicted and fetched again, as an old block on a later read. A wrong slot counter or segment counter shows on the next `vid_valid`, as a gap other than `VID_PERIOD`, a segment number out of order, or segment data that differs from the buffer model. A broken priority shows as a hit acknowledged one cycle too early in a slot cycle.

// File: rtl/pb_pkg.sv
package pb_pkg;
  typedef enum logic [0:0] {LD_IDLE, LD_BUSY} ld_state_e;

  // linear block index of a tile coordinate within a row
  function automatic int unsigned tile_index(input int unsigned bx,
                                             input int unsigned by,
                                             input int unsigned cols);
    return by * cols + bx;
  endfunction

  // next video segment with wraparound
  function automatic int unsigned seg_step(input int unsigned seg,
                                           input int unsigned nseg);
    return (seg == nseg - 1) ? 0 : seg + 1;
  endfunction
endpackage

// File: rtl/pb_video_timer.sv
module pb_video_timer #(
  parameter int VID_PERIOD = 60,
  parameter int NSEG       = 16,
  localparam int CW   = $clog2(VID_PERIOD),
  localparam int SEGW = $clog2(NSEG)
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic            vid_due,
  output logic [SEGW-1:0] seg
);
  logic [CW-1:0] cnt_q;

  assign vid_due = (cnt_q == CW'(VID_PERIOD - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      seg   <= '0;
    end else begin
      cnt_q <= vid_due ? '0 : cnt_q + 1'b1;
      if (vid_due) seg <= SEGW'(pb_pkg::seg_step(32'(seg), NSEG));
    end
  end
endmodule

// File: rtl/pb_row_ctrl.sv
module pb_row_ctrl #(
  parameter int ROW_AW   = 3,
  parameter int LOAD_CYC = 6,
  localparam int LCW = (LOAD_CYC > 1) ? $clog2(LOAD_CYC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic [ROW_AW-1:0] host_row,
  input  logic              vid_due,
  output logic              host_rdy,
  output logic              hit,
  output logic              load_start,
  output logic              load_done,
  output logic [ROW_AW-1:0] mem_rd_row
);
  pb_pkg::ld_state_e state_q;
  logic              valid_q;
  logic [ROW_AW-1:0] tag_q;
  logic [LCW-1:0]    ld_cnt_q;

  assign host_rdy   = (state_q == pb_pkg::LD_IDLE) && !vid_due;
  assign hit        = valid_q && (tag_q == host_row);
  assign load_start = host_req && host_rdy && !hit;
  // capture waits out a video slot so the two never share an edge
  assign load_done  = (state_q == pb_pkg::LD_BUSY) &&
                      (ld_cnt_q == LCW'(LOAD_CYC - 1)) && !vid_due;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= pb_pkg::LD_IDLE;
      valid_q    <= 1'b0;
      tag_q      <= '0;
      ld_cnt_q   <= '0;
      mem_rd_row <= '0;
    end else if (load_start) begin
      state_q    <= pb_pkg::LD_BUSY;
      mem_rd_row <= host_row;
      ld_cnt_q   <= '0;
    end else if (load_done) begin
      state_q <= pb_pkg::LD_IDLE;
      valid_q <= 1'b1;
      tag_q   <= mem_rd_row;
    end else if (state_q == pb_pkg::LD_BUSY &&
                 ld_cnt_q != LCW'(LOAD_CYC - 1)) begin
      ld_cnt_q <= ld_cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pb_store.sv
module pb_store #(
  parameter int ROW_W = 640,
  parameter int BLK_W = 16,
  parameter int VID_W = 40,
  parameter int BIW   = 6,
  parameter int SEGW  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [ROW_W-1:0] load_data,
  input  logic             wr_en,
  input  logic [BIW-1:0]   blk,
  input  logic [BLK_W-1:0] wr_data,
  output logic [BLK_W-1:0] rd_data,
  input  logic [SEGW-1:0]  seg,
  output logic [VID_W-1:0] seg_data
);
  logic [ROW_W-1:0] row_q;

  assign rd_data  = row_q[int'(blk) * BLK_W +: BLK_W];
  assign seg_data = row_q[int'(seg) * VID_W +: VID_W];

  always_ff @(posedge clk) begin
    if (!rst_n)       row_q <= '0;
    else if (load_en) row_q <= load_data;
    else if (wr_en)   row_q[int'(blk) * BLK_W +: BLK_W] <= wr_data;
  end
endmodule

// File: rtl/pagebuf_bank.sv
module pagebuf_bank #(
  parameter int ROW_AW     = 3,
  parameter int BLK_W      = 16,
  parameter int TILE_COLS  = 8,
  parameter int TILE_ROWS  = 5,
  parameter int VID_W      = 40,
  parameter int VID_PERIOD = 60,
  parameter int LOAD_CYC   = 6,
  localparam int NBLK  = TILE_COLS * TILE_ROWS,
  localparam int ROW_W = NBLK * BLK_W,
  localparam int NSEG  = ROW_W / VID_W,
  localparam int BXW   = $clog2(TILE_COLS),
  localparam int BYW   = $clog2(TILE_ROWS),
  localparam int BIW   = $clog2(NBLK),
  localparam int SEGW  = $clog2(NSEG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ROW_AW-1:0] host_row,
  input  logic [BXW-1:0]    host_bx,
  input  logic [BYW-1:0]    host_by,
  input  logic [BLK_W-1:0]  host_wdata,
  output logic              host_rdy,
  output logic              host_ack,
  output logic [BLK_W-1:0]  host_rdata,
  output logic [ROW_AW-1:0] mem_rd_row,
  input  logic [ROW_W-1:0]  mem_rd_data,
  output logic              mem_wr_en,
  output logic [ROW_AW-1:0] mem_wr_row,
  output logic [BIW-1:0]    mem_wr_blk,
  output logic [BLK_W-1:0]  mem_wr_data,
  output logic              vid_valid,
  output logic [SEGW-1:0]   vid_seg,
  output logic [VID_W-1:0]  vid_data
);
  // named internal events, observed by the bound checker
  logic             vid_due;
  logic             hit;
  logic             load_start;
  logic             load_done;
  logic             host_acc;
  logic [BIW-1:0]   blk_idx;
  logic [SEGW-1:0]  seg_cur;
  logic [BLK_W-1:0] blk_rd;
  logic [VID_W-1:0] seg_rd;

  assign blk_idx  = BIW'(pb_pkg::tile_index(32'(host_bx), 32'(host_by), TILE_COLS));
  assign host_acc = host_req && host_rdy && hit;

  pb_video_timer #(.VID_PERIOD(VID_PERIOD), .NSEG(NSEG)) u_timer (
    .clk(clk), .rst_n(rst_n), .vid_due(vid_due), .seg(seg_cur)
  );

  pb_row_ctrl #(.ROW_AW(ROW_AW), .LOAD_CYC(LOAD_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_row(host_row),
    .vid_due(vid_due), .host_rdy(host_rdy), .hit(hit),
    .load_start(load_start), .load_done(load_done), .mem_rd_row(mem_rd_row)
  );

  pb_store #(.ROW_W(ROW_W), .BLK_W(BLK_W), .VID_W(VID_W), .BIW(BIW), .SEGW(SEGW)) u_store (
    .clk(clk), .rst_n(rst_n), .load_en(load_done), .load_data(mem_rd_data),
    .wr_en(host_acc && host_we), .blk(blk_idx), .wr_data(host_wdata),
    .rd_data(blk_rd), .seg(seg_cur), .seg_data(seg_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_ack    <= 1'b0;
      host_rdata  <= '0;
      mem_wr_en   <= 1'b0;
      mem_wr_row  <= '0;
      mem_wr_blk  <= '0;
      mem_wr_data <= '0;
      vid_valid   <= 1'b0;
      vid_seg     <= '0;
      vid_data    <= '0;
    end else begin
      host_ack  <= host_acc;
      mem_wr_en <= host_acc && host_we;
      vid_valid <= vid_due;
      if (host_acc) begin
        host_rdata  <= blk_rd;
        mem_wr_row  <= host_row;
        mem_wr_blk  <= blk_idx;
        mem_wr_data <= host_wdata;
      end
      if (vid_due) begin
        vid_seg  <= seg_cur;
        vid_data <= seg_rd;
      end
    end
  end
endmodule

// File: rtl/pagebuf_bank_chk.sv
module pagebuf_bank_chk #(
  parameter int VID_PERIOD = 60,
  parameter int NSEG       = 16,
  localparam int SEGW = $clog2(NSEG),
  localparam int GW   = $clog2(VID_PERIOD) + 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            host_rdy,
  input logic            host_ack,
  input logic            host_we,
  input logic            mem_wr_en,
  input logic            vid_valid,
  input logic [SEGW-1:0] vid_seg,
  input logic            vid_due,
  input logic            host_acc,
  input logic            load_start
);
  logic [GW-1:0]   gap_q;
  logic            seen_q;
  logic [SEGW-1:0] exp_seg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q     <= '0;
      seen_q    <= 1'b0;
      exp_seg_q <= '0;
    end else if (vid_valid) begin
      gap_q     <= GW'(1);
      seen_q    <= 1'b1;
      exp_seg_q <= (exp_seg_q == SEGW'(NSEG - 1)) ? '0 : exp_seg_q + 1'b1;
    end else if (gap_q != '1) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  AST_LOAD_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    load_start |=> !host_rdy); // R3
  AST_ACK_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    host_acc |=> host_ack); // R4
  AST_WRITE_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (host_acc && host_we) |=> mem_wr_en); // R5
  AST_VID_AFTER_DUE: assert property (@(posedge clk) disable iff (!rst_n)
    vid_due |=> vid_valid); // R6
  AST_VID_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_valid && seen_q) |-> (gap_q == GW'(VID_PERIOD))); // R6
  AST_SEG_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    vid_valid |-> (vid_seg == exp_seg_q)); // R7
  AST_VID_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    vid_due |-> !host_rdy); // R8
endmodule

bind pagebuf_bank pagebuf_bank_chk #(.VID_PERIOD(VID_PERIOD), .NSEG(NSEG)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_rdy(host_rdy), .host_ack(host_ack),
  .host_we(host_we), .mem_wr_en(mem_wr_en), .vid_valid(vid_valid),
  .vid_seg(vid_seg), .vid_due(vid_due), .host_acc(host_acc),
  .load_start(load_start)
);

// File: tb/pagebuf_bank_tb.sv
module pagebuf_bank_tb;
  localparam int TCOLS = 8;
  localparam int TROWS = 5;
  localparam int BW    = 16;
  localparam int VW    = 40;
  localparam int P     = 60;
  localparam int LC    = 6;
  localparam int RW    = TCOLS * TROWS * BW;
  localparam int NS    = RW / VW;

  typedef struct packed {
    logic        we;
    logic [2:0]  row;
    logic [2:0]  bx;
    logic [2:0]  by;
    logic [15:0] data;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{1'b0, 3'd2, 3'd1, 3'd0, 16'h0000},
    '{1'b1, 3'd2, 3'd1, 3'd0, 16'hA5A5},
    '{1'b0, 3'd2, 3'd1, 3'd0, 16'h0000},
    '{1'b1, 3'd2, 3'd7, 3'd4, 16'h1234},
    '{1'b0, 3'd5, 3'd0, 3'd0, 16'h0000},
    '{1'b1, 3'd5, 3'd3, 3'd2, 16'hBEEF},
    '{1'b0, 3'd2, 3'd7, 3'd4, 16'h0000},
    '{1'b0, 3'd2, 3'd1, 3'd0, 16'h0000},
    '{1'b1, 3'd2, 3'd0, 3'd0, 16'h0F0F},
    '{1'b0, 3'd5, 3'd3, 3'd2, 16'h0000},
    '{1'b0, 3'd0, 3'd2, 3'd3, 16'h0000},
    '{1'b0, 3'd2, 3'd0, 3'd0, 16'h0000}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host_req = 1'b0;
  logic          host_we = 1'b0;
  logic [2:0]    host_row = '0;
  logic [2:0]    host_bx = '0;
  logic [2:0]    host_by = '0;
  logic [BW-1:0] host_wdata = '0;
  logic          host_rdy, host_ack;
  logic [BW-1:0] host_rdata;
  logic [2:0]    mem_rd_row;
  logic [RW-1:0] mem_rd_data;
  logic          mem_wr_en;
  logic [2:0]    mem_wr_row;
  logic [5:0]    mem_wr_blk;
  logic [BW-1:0] mem_wr_data;
  logic          vid_valid;
  logic [3:0]    vid_seg;
  logic [VW-1:0] vid_data;

  logic [RW-1:0] mem_model [8];
  logic [RW-1:0] sh_buf = '0;
  logic [2:0]    sh_row = '0;
  bit            sh_valid = 1'b0;
  int checks = 0;
  int errors = 0;
  int ecnt = 0;
  int last_vid_e = 0;
  int exp_seg = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pagebuf_bank u_dut (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_row(host_row), .host_bx(host_bx), .host_by(host_by),
    .host_wdata(host_wdata), .host_rdy(host_rdy), .host_ack(host_ack),
    .host_rdata(host_rdata), .mem_rd_row(mem_rd_row), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_row(mem_wr_row), .mem_wr_blk(mem_wr_blk),
    .mem_wr_data(mem_wr_data), .vid_valid(vid_valid), .vid_seg(vid_seg),
    .vid_data(vid_data)
  );

  assign mem_rd_data = mem_model[mem_rd_row];

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) ecnt <= rst_n ? ecnt + 1 : 0;

  // array model: takes write-through traffic
  always @(negedge clk)
    if (rst_n && mem_wr_en)
      mem_model[mem_wr_row][int'(mem_wr_blk) * BW +: BW] <= mem_wr_data;

  // video monitor
  always @(negedge clk) begin
    if (rst_n && vid_valid) begin
      chk(ecnt == last_vid_e + P, "R6 video slot spacing", 64'(ecnt), 64'(last_vid_e + P));
      chk(int'(vid_seg) == exp_seg, "R7 segment order", 64'(vid_seg), 64'(exp_seg));
      chk(vid_data == sh_buf[exp_seg * VW +: VW], "R7 segment data",
          64'(vid_data), 64'(sh_buf[exp_seg * VW +: VW]));
      last_vid_e = ecnt;
      exp_seg = (exp_seg == NS - 1) ? 0 : exp_seg + 1;
    end
  end

  task automatic do_op(input vec_t v);
    bit miss;
    int lat;
    int blk;
    @(negedge clk);
    while (!vid_valid) @(negedge clk);
    miss = !(sh_valid && sh_row == v.row);
    blk = int'(v.by) * TCOLS + int'(v.bx);
    host_req = 1'b1; host_we = v.we; host_row = v.row;
    host_bx = v.bx; host_by = v.by; host_wdata = v.data;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (lat == 1 && miss)
        chk(host_rdy == 1'b0, "R3 not ready during fetch", 64'(host_rdy), 64'd0);
    end while (!host_ack && lat < 100);
    host_req = 1'b0;
    chk(lat == (miss ? LC + 2 : 1), miss ? "R3 fetch latency" : "R4 hit latency",
        64'(lat), 64'(miss ? LC + 2 : 1));
    if (miss) begin
      sh_buf = mem_model[v.row];
      sh_row = v.row;
      sh_valid = 1'b1;
    end
    if (!v.we) begin
      chk(host_rdata == sh_buf[blk * BW +: BW], miss ? "R9 refetched data" : "R4 hit data",
          64'(host_rdata), 64'(sh_buf[blk * BW +: BW]));
    end else begin
      chk(mem_wr_en == 1'b1, "R5 write-through strobe", 64'(mem_wr_en), 64'd1);
      chk(mem_wr_row == v.row && mem_wr_data == v.data, "R5 write-through row/data",
          {48'(mem_wr_row), mem_wr_data}, {48'(v.row), v.data});
      chk(int'(mem_wr_blk) == blk, "R2 tile block index", 64'(mem_wr_blk), 64'(blk));
      sh_buf[blk * BW +: BW] = v.data;
    end
  endtask

  initial begin
    for (int r = 0; r < 8; r++)
      for (int b = 0; b < TCOLS * TROWS; b++)
        mem_model[r][b * BW +: BW] = 16'(16'h1000 + r * 256 + b * 3);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(host_ack == 0 && vid_valid == 0 && mem_wr_en == 0, "R1 reset outputs",
        {61'd0, host_ack, vid_valid, mem_wr_en}, 64'd0);
    chk(host_rdy == 1'b1, "R1 ready after reset", 64'(host_rdy), 64'd1);

    for (int i = 0; i < 12; i++) do_op(VECS[i]);

    // R8: hit request held across a video-due cycle
    @(negedge clk);
    while (!vid_valid) @(negedge clk);
    while ((ecnt % P) != P - 1) @(negedge clk);
    chk(host_rdy == 1'b0, "R8 not ready in slot cycle", 64'(host_rdy), 64'd0);
    host_req = 1'b1; host_we = 1'b0; host_row = 3'd2; host_bx = 3'd0; host_by = 3'd0;
    begin
      int lat = 0;
      do begin @(negedge clk); lat++; end while (!host_ack && lat < 100);
      host_req = 1'b0;
      chk(lat == 2, "R8 request delayed by slot", 64'(lat), 64'd2);
      chk(host_rdata == 16'h0F0F, "R8 delayed read data", 64'(host_rdata), 64'h0F0F);
    end

    // let the segment counter wrap at least once more
    repeat (P * (NS + 1)) @(negedge clk);
    chk(exp_seg != 0 || last_vid_e > 0, "R7 segments delivered", 64'(exp_seg), 64'd0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule